// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address once the translation buffer has missed. It accepts one request at a time, carrying the address, a write flag and a user flag. It fetches the directory entry through a single-word read port, and then fetches the table entry that the directory entry points to. It checks the present and permission bits of both entries. When the access is allowed it writes the accessed and dirty flags back to memory. It then returns the physical address, together with a fill pulse for the translation buffer. When the access is refused it returns a fault record instead.

The virtual address is split into three fields. The top ten bits index the directory and the next ten index the table. The low twelve bits pass through unchanged as the byte offset in the page. Both tables and pages are aligned to 4 KB. Large pages are not decoded. Memory reads and writes each use a request/response handshake, and the walker holds each request until the response arrives.

Top module: `pt_walker`

## Requirements
- R1: After reset, and whenever the walker is idle, `req_ready_o` is 1 and no memory read or write request is raised. `done_o`, `fault_o` and `fill_valid_o` are 0 at those times.
- R2: The first read is at address {dir_frame_i, 12'b0} + 4·VA[31:22]. The second read is at address {entry[31:12], 12'b0} + 4·VA[21:12], where entry is the word returned by the first read.
- R3: When bit 0 (present) of the directory entry is 0, the walk ends after one read with a fault whose cause is 0. When bit 0 of the table entry is 0, the walk ends after two reads with a fault whose cause is 0. `done_o` and `fault_o` are never 1 together.
- R4: The walker ANDs bit 1 (writable) of the two entries, and ANDs bit 2 (user allowed) of the two entries. A write with a combined writable bit of 0, or a user access with a combined user bit of 0, ends in a fault with cause 1. Every fault reports the faulting VA and the request's write and user flags.
- R5: A walk that succeeds raises `done_o` for exactly one cycle, with `pa_o` = {table entry[31:12], VA[11:0]}.
- R6: A walk that succeeds sets bit 5 (accessed) in both entries in memory. On a write it also sets bit 6 (dirty) in the table entry. All other bits are left unchanged. A fault writes nothing to memory. A write request holds its address and data until it is acknowledged.
- R7: A write-back is issued only for an entry whose stored value actually changes. When the needed bits are already set, that entry is not written.
- R8: In the same cycle as `done_o`, `fill_valid_o` pulses. `fill_vpn_o` carries VA[31:12] and `fill_pte_o` carries the table entry after its accessed and dirty updates.
- R9: A request is taken only while `req_ready_o` is 1. A request held while a walk is in progress does not change the walk's result, and it does not start a walk.
- R10: While a read is pending without `mem_rd_valid_i`, the read request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_frame_i | input | 20 | Frame number of the page directory |
| req_valid_i | input | 1 | Translation request |
| req_va_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is from user mode |
| req_ready_o | output | 1 | Walker is idle and takes a request |
| mem_rd_req_o | output | 1 | Memory read request |
| mem_rd_addr_o | output | 32 | Byte address of the word to read |
| mem_rd_valid_i | input | 1 | Read data is valid this cycle |
| mem_rd_data_i | input | 32 | Read data |
| mem_wr_req_o | output | 1 | Memory write request |
| mem_wr_addr_o | output | 32 | Byte address of the word to write |
| mem_wr_data_o | output | 32 | Write data |
| mem_wr_ack_i | input | 1 | Write accepted this cycle |
| done_o | output | 1 | One-cycle pulse: translation succeeded |
| pa_o | output | 32 | Physical address, valid with `done_o` |
| fault_o | output | 1 | One-cycle pulse: walk ended in a fault |
| fault_cause_o | output | 1 | 0 = entry not present, 1 = protection violation |
| fault_va_o | output | 32 | Virtual address of the walk |
| fault_write_o | output | 1 | Write flag of the faulting request |
| fault_user_o | output | 1 | User flag of the faulting request |
| fill_valid_o | output | 1 | One-cycle pulse: translation buffer fill |
| fill_vpn_o | output | 20 | Virtual page number for the fill |
| fill_pte_o | output | 32 | Updated table entry for the fill |

## Verification
The completion pulse and the translation buffer fill fall in the same cycle. In that cycle the bench compares the physical address, the fill's page number and the fill's entry against one bench model, and it also checks the entries in memory. A request that arrives while a walk is still running is held on the request port with a different address until completion. The walk's result must then match the first address, and no extra read may follow. Random memory latencies force the read and write handshakes to stall at various points. The bench logs every read address, and it confirms that no write occurs on a fault or when the accessed and dirty bits are already set.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    // Bit positions inside a directory or table entry
    localparam int unsigned ENT_PRESENT = 0;
    localparam int unsigned ENT_WRITE   = 1;
    localparam int unsigned ENT_USER    = 2;
    localparam int unsigned ENT_ACCESS  = 5;
    localparam int unsigned ENT_DIRTY   = 6;

    typedef enum logic {
        CAUSE_ABSENT = 1'b0,
        CAUSE_PROT   = 1'b1
    } fault_cause_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_RD_DIR = 3'd1,
        S_RD_TBL = 3'd2,
        S_WB_DIR = 3'd3,
        S_WB_TBL = 3'd4,
        S_DONE   = 3'd5,
        S_FAULT  = 3'd6
    } walk_state_e;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned ENT_W  = 2
) (
    input  logic [ADDR_W-OFF_W-1:0] dir_frame_i,
    input  logic [ADDR_W-OFF_W-1:0] ent_frame_i,
    input  logic [ADDR_W-1:0]       va_i,
    output logic [ADDR_W-1:0]       dir_addr_o,
    output logic [ADDR_W-1:0]       tbl_addr_o,
    output logic [ADDR_W-1:0]       pa_o
);
    localparam int unsigned FRAME_W = ADDR_W - OFF_W;

    logic [IDX_W-1:0]  hi_idx;
    logic [IDX_W-1:0]  lo_idx;
    logic [ADDR_W-1:0] dir_base;
    logic [ADDR_W-1:0] ent_base;

    always_comb begin
        hi_idx     = va_i[ADDR_W-1 -: IDX_W];
        lo_idx     = va_i[OFF_W +: IDX_W];
        dir_base   = {dir_frame_i, {OFF_W{1'b0}}};
        ent_base   = {ent_frame_i, {OFF_W{1'b0}}};
        dir_addr_o = dir_base + (ADDR_W'(hi_idx) << ENT_W);
        tbl_addr_o = ent_base + (ADDR_W'(lo_idx) << ENT_W);
        pa_o       = {ent_frame_i[FRAME_W-1:0], va_i[OFF_W-1:0]};
    end

endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
    import pt_walk_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pde_i,
    input  logic [ADDR_W-1:0] pte_i,
    input  logic              write_i,
    input  logic              user_i,
    output logic              pde_absent_o,
    output logic              pte_absent_o,
    output logic              prot_o,
    output logic [ADDR_W-1:0] pde_upd_o,
    output logic [ADDR_W-1:0] pte_upd_o,
    output logic              pde_wb_o,
    output logic              pte_wb_o
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1) << ENT_ACCESS;
    localparam logic [ADDR_W-1:0] D_MASK = ADDR_W'(1) << ENT_DIRTY;

    logic wr_ok;
    logic usr_ok;

    always_comb begin
        pde_absent_o = !pde_i[ENT_PRESENT];
        pte_absent_o = !pte_i[ENT_PRESENT];
        wr_ok        = pde_i[ENT_WRITE] & pte_i[ENT_WRITE];
        usr_ok       = pde_i[ENT_USER] & pte_i[ENT_USER];
        prot_o       = (write_i && !wr_ok) || (user_i && !usr_ok);
        pde_upd_o    = pde_i | A_MASK;
        pte_upd_o    = pte_i | A_MASK | (write_i ? D_MASK : '0);
        pde_wb_o     = (pde_upd_o != pde_i);
        pte_wb_o     = (pte_upd_o != pte_i);
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned ENT_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-OFF_W-1:0] dir_frame_i,
    input  logic                    req_valid_i,
    input  logic [ADDR_W-1:0]       req_va_i,
    input  logic                    req_write_i,
    input  logic                    req_user_i,
    output logic                    req_ready_o,
    output logic                    mem_rd_req_o,
    output logic [ADDR_W-1:0]       mem_rd_addr_o,
    input  logic                    mem_rd_valid_i,
    input  logic [ADDR_W-1:0]       mem_rd_data_i,
    output logic                    mem_wr_req_o,
    output logic [ADDR_W-1:0]       mem_wr_addr_o,
    output logic [ADDR_W-1:0]       mem_wr_data_o,
    input  logic                    mem_wr_ack_i,
    output logic                    done_o,
    output logic [ADDR_W-1:0]       pa_o,
    output logic                    fault_o,
    output logic                    fault_cause_o,
    output logic [ADDR_W-1:0]       fault_va_o,
    output logic                    fault_write_o,
    output logic                    fault_user_o,
    output logic                    fill_valid_o,
    output logic [ADDR_W-OFF_W-1:0] fill_vpn_o,
    output logic [ADDR_W-1:0]       fill_pte_o
);
    localparam int unsigned FRAME_W = ADDR_W - OFF_W;

    typedef struct packed {
        walk_state_e       state;
        logic [ADDR_W-1:0] va;
        logic              write;
        logic              user;
        logic [ADDR_W-1:0] pde;
        logic [ADDR_W-1:0] pte;
        logic [ADDR_W-1:0] pde_addr;
        logic [ADDR_W-1:0] rd_addr;
        logic [ADDR_W-1:0] pa;
        logic              pte_wb;
        fault_cause_e      cause;
    } walk_regs_t;

    walk_regs_t walk_d, walk_q;

    logic [ADDR_W-1:0] va_sel;
    logic [ADDR_W-1:0] dir_addr;
    logic [ADDR_W-1:0] tbl_addr;
    logic [ADDR_W-1:0] pa_calc;
    logic [ADDR_W-1:0] pde_sel;
    logic              pde_absent, pte_absent, prot;
    logic [ADDR_W-1:0] pde_upd, pte_upd;
    logic              pde_wb, pte_wb;

    assign va_sel  = (walk_q.state == S_IDLE) ? req_va_i : walk_q.va;
    assign pde_sel = (walk_q.state == S_RD_DIR) ? mem_rd_data_i : walk_q.pde;

    pt_addr_gen #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .ENT_W  (ENT_W)
    ) u_addr (
        .dir_frame_i (dir_frame_i),
        .ent_frame_i (mem_rd_data_i[ADDR_W-1:OFF_W]),
        .va_i        (va_sel),
        .dir_addr_o  (dir_addr),
        .tbl_addr_o  (tbl_addr),
        .pa_o        (pa_calc)
    );

    pt_perm_check #(
        .ADDR_W (ADDR_W)
    ) u_perm (
        .pde_i        (pde_sel),
        .pte_i        (mem_rd_data_i),
        .write_i      (walk_q.write),
        .user_i       (walk_q.user),
        .pde_absent_o (pde_absent),
        .pte_absent_o (pte_absent),
        .prot_o       (prot),
        .pde_upd_o    (pde_upd),
        .pte_upd_o    (pte_upd),
        .pde_wb_o     (pde_wb),
        .pte_wb_o     (pte_wb)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.state)
            S_IDLE: begin
                if (req_valid_i) begin
                    walk_d.va       = req_va_i;
                    walk_d.write    = req_write_i;
                    walk_d.user     = req_user_i;
                    walk_d.pde_addr = dir_addr;
                    walk_d.rd_addr  = dir_addr;
                    walk_d.state    = S_RD_DIR;
                end
            end
            S_RD_DIR: begin
                if (mem_rd_valid_i) begin
                    walk_d.pde = mem_rd_data_i;
                    if (pde_absent) begin
                        walk_d.cause = CAUSE_ABSENT;
                        walk_d.state = S_FAULT;
                    end else begin
                        walk_d.rd_addr = tbl_addr;
                        walk_d.state   = S_RD_TBL;
                    end
                end
            end
            S_RD_TBL: begin
                if (mem_rd_valid_i) begin
                    walk_d.pte = mem_rd_data_i;
                    if (pte_absent) begin
                        walk_d.cause = CAUSE_ABSENT;
                        walk_d.state = S_FAULT;
                    end else if (prot) begin
                        walk_d.cause = CAUSE_PROT;
                        walk_d.state = S_FAULT;
                    end else begin
                        walk_d.pde    = pde_upd;
                        walk_d.pte    = pte_upd;
                        walk_d.pa     = pa_calc;
                        walk_d.pte_wb = pte_wb;
                        if (pde_wb)      walk_d.state = S_WB_DIR;
                        else if (pte_wb) walk_d.state = S_WB_TBL;
                        else             walk_d.state = S_DONE;
                    end
                end
            end
            S_WB_DIR: begin
                if (mem_wr_ack_i) begin
                    walk_d.state = walk_q.pte_wb ? S_WB_TBL : S_DONE;
                end
            end
            S_WB_TBL: begin
                if (mem_wr_ack_i) begin
                    walk_d.state = S_DONE;
                end
            end
            S_DONE:  walk_d.state = S_IDLE;
            S_FAULT: walk_d.state = S_IDLE;
            default: walk_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign req_ready_o   = (walk_q.state == S_IDLE);
    assign mem_rd_req_o  = (walk_q.state == S_RD_DIR) || (walk_q.state == S_RD_TBL);
    assign mem_rd_addr_o = walk_q.rd_addr;
    assign mem_wr_req_o  = (walk_q.state == S_WB_DIR) || (walk_q.state == S_WB_TBL);
    assign mem_wr_addr_o = (walk_q.state == S_WB_DIR) ? walk_q.pde_addr : walk_q.rd_addr;
    assign mem_wr_data_o = (walk_q.state == S_WB_DIR) ? walk_q.pde : walk_q.pte;
    assign done_o        = (walk_q.state == S_DONE);
    assign pa_o          = walk_q.pa;
    assign fault_o       = (walk_q.state == S_FAULT);
    assign fault_cause_o = walk_q.cause;
    assign fault_va_o    = walk_q.va;
    assign fault_write_o = walk_q.write;
    assign fault_user_o  = walk_q.user;
    assign fill_valid_o  = (walk_q.state == S_DONE);
    assign fill_vpn_o    = walk_q.va[ADDR_W-1:OFF_W];
    assign fill_pte_o    = walk_q.pte;

    // Idle means no memory traffic (R1)
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (!mem_rd_req_o && !mem_wr_req_o && !done_o && !fault_o));

    // Success and fault are exclusive (R3)
    assert_done_fault_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fault_o));

    // Completion is a single-cycle pulse, followed by idle (R5)
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && req_ready_o));

    // Stalled write keeps address and data (R6)
    assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req_o && !mem_wr_ack_i) |=>
        (mem_wr_req_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o)));

    // Fill entry frame agrees with the reported PA and is marked accessed (R8)
    assert_fill_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid_o |-> (fill_pte_o[ADDR_W-1:OFF_W] == pa_o[ADDR_W-1:OFF_W]
                          && fill_pte_o[ENT_ACCESS] && fill_pte_o[ENT_PRESENT]
                          && FRAME_W == $bits(fill_vpn_o)));

    // Walk VA stays fixed while busy, whatever the request port does (R9)
    assert_busy_va_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready_o |=> $stable(fault_va_o));

    // Stalled read keeps request and address (R10)
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req_o && !mem_rd_valid_i) |=> (mem_rd_req_o && $stable(mem_rd_addr_o)));

endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] dir_frame;
    logic        req_valid, req_write, req_user;
    logic [31:0] req_va;
    logic        req_ready;
    logic        rd_req, rd_valid;
    logic [31:0] rd_addr, rd_data;
    logic        wr_req, wr_ack;
    logic [31:0] wr_addr, wr_data;
    logic        done, fault, fault_cause, fault_write, fault_user, fill_valid;
    logic [31:0] pa, fault_va, fill_pte;
    logic [19:0] fill_vpn;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] rd_log [4];
    int rd_n = 0;
    int wr_n = 0;
    int rd_wait = 0;
    int wr_wait = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n), .dir_frame_i(dir_frame),
        .req_valid_i(req_valid), .req_va_i(req_va), .req_write_i(req_write),
        .req_user_i(req_user), .req_ready_o(req_ready),
        .mem_rd_req_o(rd_req), .mem_rd_addr_o(rd_addr),
        .mem_rd_valid_i(rd_valid), .mem_rd_data_i(rd_data),
        .mem_wr_req_o(wr_req), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data),
        .mem_wr_ack_i(wr_ack), .done_o(done), .pa_o(pa), .fault_o(fault),
        .fault_cause_o(fault_cause), .fault_va_o(fault_va),
        .fault_write_o(fault_write), .fault_user_o(fault_user),
        .fill_valid_o(fill_valid), .fill_vpn_o(fill_vpn), .fill_pte_o(fill_pte)
    );

    function automatic logic [31:0] mem_get(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory model: read responder with random latency
    initial begin
        rd_valid = 1'b0; rd_data = '0;
        forever begin
            @(negedge clk);
            if (rd_valid) rd_valid = 1'b0;
            else if (rd_req) begin
                if (rd_wait > 0) rd_wait--;
                else begin
                    rd_data  = mem_get(rd_addr);
                    rd_valid = 1'b1;
                    if (rd_n < 4) rd_log[rd_n] = rd_addr;
                    rd_n++;
                    rd_wait = $urandom % 3;
                end
            end
        end
    end

    // Memory model: write responder with random latency
    initial begin
        wr_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (wr_ack) wr_ack = 1'b0;
            else if (wr_req) begin
                if (wr_wait > 0) wr_wait--;
                else begin
                    mem[wr_addr] = wr_data;
                    wr_ack = 1'b1;
                    wr_n++;
                    wr_wait = $urandom % 3;
                end
            end
        end
    end

    // Build one directory entry and one table entry for a VA
    task automatic setup(input logic [19:0] dfr, input logic [31:0] va,
                         input logic [19:0] tfr, input logic [11:0] pde_fl,
                         input logic [19:0] pfr, input logic [11:0] pte_fl);
        mem.delete();
        dir_frame = dfr;
        mem[{dfr, 12'h0} + {20'h0, va[31:22], 2'b00}] = {tfr, pde_fl};
        mem[{tfr, 12'h0} + {20'h0, va[21:12], 2'b00}] = {pfr, pte_fl};
    endtask

    task automatic run_walk(input logic [31:0] va, input bit w, input bit u, input bit hog, input string tag);
        logic [31:0] pde_a, pte_a, pde, pte, npde, npte, exp_pa;
        bit e_fault, e_cause;
        int e_reads, e_writes, cyc;
        pde_a = {dir_frame, 12'h0} + {20'h0, va[31:22], 2'b00};
        pde   = mem_get(pde_a);
        pte_a = {pde[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
        pte   = mem_get(pte_a);
        e_fault = 1'b0; e_cause = 1'b0; e_reads = 2; e_writes = 0;
        npde = pde; npte = pte;
        exp_pa = {pte[31:12], va[11:0]};
        if (!pde[0]) begin
            e_fault = 1'b1; e_reads = 1;
        end else if (!pte[0]) begin
            e_fault = 1'b1;
        end else if ((w && !(pde[1] & pte[1])) || (u && !(pde[2] & pte[2]))) begin
            e_fault = 1'b1; e_cause = 1'b1;
        end else begin
            npde = pde | 32'h20;
            npte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
            e_writes = (npde != pde) + (npte != pte);
        end
        rd_n = 0; wr_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = w; req_user = u;
        @(posedge clk);
        @(negedge clk);
        if (hog) begin
            req_va = va ^ 32'hFFFFF000; req_write = !w; req_user = !u;
        end else req_valid = 1'b0;
        cyc = 0;
        while (!(done || fault) && cyc < 200) begin
            @(negedge clk); cyc++;
        end
        req_valid = 1'b0;
        chk(fault == e_fault, {tag, " R3/R4 fault flag"}, 32'(fault), 32'(e_fault));
        chk(done == !e_fault, {tag, " R5 done flag"}, 32'(done), 32'(!e_fault));
        chk(rd_n == e_reads, {tag, " R3 read count"}, 32'(rd_n), 32'(e_reads));
        if (rd_n >= 1) chk(rd_log[0] == pde_a, {tag, " R2 dir address"}, rd_log[0], pde_a);
        if (rd_n >= 2) chk(rd_log[1] == pte_a, {tag, " R2 table address"}, rd_log[1], pte_a);
        chk(wr_n == e_writes, {tag, " R7 write count"}, 32'(wr_n), 32'(e_writes));
        if (e_fault) begin
            chk(fault_cause == e_cause, {tag, " R4 cause"}, 32'(fault_cause), 32'(e_cause));
            chk(fault_va == va, {tag, " R4 fault va"}, fault_va, va);
            chk({fault_write, fault_user} == {w, u}, {tag, " R4 fault flags"},
                32'({fault_write, fault_user}), 32'({w, u}));
            chk(!fill_valid, {tag, " R8 no fill on fault"}, 32'(fill_valid), 32'h0);
        end else begin
            chk(pa == exp_pa, {tag, " R5 pa"}, pa, exp_pa);
            chk(fill_valid, {tag, " R8 fill with done"}, 32'(fill_valid), 32'h1);
            chk(fill_vpn == va[31:12], {tag, " R8 fill vpn"}, 32'(fill_vpn), 32'(va[31:12]));
            chk(fill_pte == npte, {tag, " R8 fill pte"}, fill_pte, npte);
            chk(mem_get(pde_a) == npde, {tag, " R6 dir entry in memory"}, mem_get(pde_a), npde);
            chk(mem_get(pte_a) == npte, {tag, " R6 table entry in memory"}, mem_get(pte_a), npte);
        end
        @(negedge clk);
        chk(req_ready && !rd_req && !done && !fault, {tag, " R1/R9 idle after walk"},
            32'({req_ready, rd_req, done, fault}), 32'h8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_write = 1'b0; req_user = 1'b0;
        dir_frame = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready && !rd_req && !wr_req && !done && !fault && !fill_valid, "R1 reset state",
            32'({req_ready, rd_req, wr_req, done, fault, fill_valid}), 32'h20);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: directory entry absent (R3)
        setup(20'h00010, 32'h1234_5678, 20'h00020, 12'h066, 20'hABCDE, 12'h067);
        run_walk(32'h1234_5678, 1'b0, 1'b0, 1'b0, "dir-absent R3");
        // Directed: table entry absent (R3)
        setup(20'h00010, 32'h8765_4321, 20'h00020, 12'h007, 20'hABCDE, 12'h066);
        run_walk(32'h8765_4321, 1'b1, 1'b1, 1'b0, "tbl-absent R3");
        // Directed: write blocked by directory read-only bit (R4)
        setup(20'h00100, 32'h4000_1ABC, 20'h00200, 12'h005, 20'h11111, 12'h007);
        run_walk(32'h4000_1ABC, 1'b1, 1'b0, 1'b0, "ro-write R4");
        // Directed: user access blocked by table supervisor bit (R4)
        setup(20'h00100, 32'h4000_1ABC, 20'h00200, 12'h007, 20'h11111, 12'h003);
        run_walk(32'h4000_1ABC, 1'b0, 1'b1, 1'b0, "supervisor R4");
        // Directed: all bits already set, no write-back (R7)
        setup(20'h00300, 32'hFFFF_FFFF, 20'h00400, 12'h027, 20'h22222, 12'h067);
        run_walk(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, "no-writeback R7");
        // Directed: read with clear bits, dirty stays clear (R6)
        setup(20'h00300, 32'h0000_0000, 20'h00400, 12'h007, 20'h33333, 12'h007);
        run_walk(32'h0000_0000, 1'b0, 1'b1, 1'b0, "read-access R6");
        // Directed: only table dirty missing (R7)
        setup(20'h00500, 32'h0040_2010, 20'h00600, 12'h027, 20'h44444, 12'h027);
        run_walk(32'h0040_2010, 1'b1, 1'b0, 1'b0, "dirty-only R7");
        // Directed: request held during the walk is ignored (R9)
        setup(20'h00700, 32'h0C03_3FF0, 20'h00800, 12'h007, 20'h55555, 12'h007);
        run_walk(32'h0C03_3FF0, 1'b1, 1'b0, 1'b1, "busy-hold R9");

        // Random walks (R2..R10)
        for (int i = 0; i < 300; i++) begin
            logic [19:0] dfr, tfr;
            logic [11:0] dfl, tfl;
            logic [31:0] va;
            dfr = 20'($urandom);
            tfr = dfr ^ 20'(1 + ($urandom % 255));
            dfl = 12'($urandom); dfl[0] = (($urandom % 8) != 0);
            tfl = 12'($urandom); tfl[0] = (($urandom % 8) != 0);
            va  = $urandom;
            setup(dfr, va, tfr, dfl, 20'($urandom), tfl);
            run_walk(va, 1'($urandom), 1'($urandom), 1'(($urandom % 10) == 0), "random R10");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule